// File: doc/BRIEF.md
# Delay-Slot Single-Cycle Integer Core

This block is a small 32-bit core that completes one instruction per clock. It supports three fixed-length instructions: add-immediate, load-word and branch-if-not-equal. Each instruction is fetched through a combinational port. The core drives the address, and the word comes back in the same cycle. Loads work the same way. The core drives an effective address with a read strobe, and the data word comes back in the same cycle to be written into the register file at the clock edge.

Branches are delayed. The instruction after a branch always executes. A taken branch redirects fetch only after that delay-slot instruction retires, because a pending-redirect register holds the taken flag and the target for one instruction.

A load whose effective address is not word aligned is not serviced. It raises a sticky address-error output, and the core halts with its fetch address held on the faulting instruction until reset. An opcode outside the supported three raises an illegal-instruction flag for that cycle and otherwise behaves as a no-op.

Top module: `dslot_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core returns to its start state. The fetch address becomes `RESET_PC` (default 0x0000_1000), `addr_err` is 0, no redirect is pending and every register reads 0.
- R2: Opcode 6'b001001 in bits 31:26 is add-immediate. It writes rs (bits 25:21) plus the sign-extended immediate (bits 15:0) to rt (bits 20:16), modulo 2^32, with no trap on overflow.
- R3: Opcode 6'b100011 is load-word. It drives `dmem_addr` = rs + sign-extended immediate and raises `dmem_rd_en` in the same cycle when that address is word aligned. It then writes `dmem_rdata` into rt at the clock edge.
- R4: Register 0 always reads as zero, and any write to it is discarded.
- R5: Opcode 6'b000101 is branch-if-not-equal. When rs differs from rt, the instruction after the branch still executes. The fetch after it is at (branch address + 4) + (sign-extended immediate × 4).
- R6: A branch whose two registers are equal does not redirect, and fetch continues sequentially.
- R7: Outside a pending redirect or a halt, the fetch address advances by 4 each cycle.
- R8: A load whose effective address has a nonzero value in bits 1:0 keeps `dmem_rd_en` low and does not write the register file. From the next cycle `addr_err` is 1 and the fetch address stays on the faulting load.
- R9: Any opcode other than the three above sets `illegal_op` in the cycle it is presented. It writes no register, and fetch advances by 4.
- R10: If the delay-slot instruction of a taken branch is a misaligned load, the error wins. Fetch stays on the delay-slot address, and the branch target is never fetched.
- R11: Once `addr_err` is 1, no further instruction has an effect. `dmem_rd_en` and `illegal_op` stay 0, and the fetch address is frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Load effective address |
| dmem_rd_en | output | 1 | Aligned load in progress this cycle |
| dmem_rdata | input | 32 | Load data, same cycle |
| addr_err | output | 1 | Sticky misaligned-load error; core halted |
| illegal_op | output | 1 | Unknown opcode presented this cycle |

## Verification
The interesting collision is the retirement of a delay-slot instruction in the same cycle as an address error. When the pending redirect is consumed by a faulting load, both the redirect and the halt compete for the next fetch address. A directed case provokes this with a taken branch whose delay slot holds a load at an odd address. It is judged by requiring that the fetch address freeze on the delay slot, never reaching the target, while `addr_err` rises. Random instruction streams with aligned loads, wrapping adds and taken or untaken branches (never a branch in a delay slot) are compared cycle by cycle against an instruction-level model kept in the bench.

// File: rtl/dslot_pkg.sv
`timescale 1ns/1ps
// Shared encodings and decoded-instruction type for the delay-slot core.
// Assumes a fixed 32-bit instruction word with a 6-bit opcode at the top,
// two 5-bit register fields below it and a 16-bit immediate at the bottom.
package dslot_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - RIDX_W;
    localparam int RT_LSB  = RS_LSB - RIDX_W;

    localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_LW   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;

    typedef enum logic [1:0] {
        KIND_NOP,
        KIND_ADDI,
        KIND_LOAD,
        KIND_BNE
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                illegal;
        logic [RIDX_W-1:0]   rs;
        logic [RIDX_W-1:0]   rt;
        logic [IMM_W-1:0]    imm;
    } dec_t;
endpackage

// File: rtl/dslot_decode.sv
`timescale 1ns/1ps
// Instruction decoder: splits the word into fields and classifies the opcode.
// Assumes the caller masks the result when the core is halted.
module dslot_decode
    import dslot_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [OPC_W-1:0] opc;

    assign opc = instr[INSTR_W-1:OPC_LSB];

    // Classify the opcode and extract register and immediate fields.
    always_comb begin
        dec.rs      = instr[OPC_LSB-1:RS_LSB];
        dec.rt      = instr[RS_LSB-1:RT_LSB];
        dec.imm     = instr[IMM_W-1:0];
        dec.illegal = 1'b0;
        unique case (opc)
            OPC_ADDI: dec.kind = KIND_ADDI;
            OPC_LW:   dec.kind = KIND_LOAD;
            OPC_BNE:  dec.kind = KIND_BNE;
            default: begin
                dec.kind    = KIND_NOP;
                dec.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dslot_regfile.sv
`timescale 1ns/1ps
// Two-read, one-write register file with entry 0 hard-wired to zero.
// Assumes synchronous active-low reset clears every entry.
module dslot_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rs_addr,
    input  logic [AW-1:0]   rt_addr,
    output logic [XLEN-1:0] rs_data,
    output logic [XLEN-1:0] rt_data,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    // Clear on reset; write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Read ports; entry zero is forced to zero.
    always_comb begin
        rs_data = (rs_addr == '0) ? '0 : regs[rs_addr];
        rt_data = (rt_addr == '0) ? '0 : regs[rt_addr];
    end

    // R4
    r4_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_addr == '0) |-> (rs_data == '0));

    // R2
    r2_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/dslot_fetch.sv
`timescale 1ns/1ps
// Program counter with a one-instruction pending redirect for delayed branches.
// Assumes "advance" is low whenever the current instruction does not retire,
// and that a branch is never placed in the delay slot of another branch.
module dslot_fetch #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 'h1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            redirect_set,
    input  logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    logic            pend_q;
    logic [XLEN-1:0] tgt_q;

    // Advance the PC, consuming any pending redirect and recording a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            pend_q <= 1'b0;
            tgt_q  <= '0;
        end else if (advance) begin
            pc_q   <= pend_q ? tgt_q : pc_q + STEP;
            pend_q <= redirect_set;
            tgt_q  <= redirect_pc;
        end
    end

    assign pc = pc_q;

    // R7
    r7_seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !pend_q) |=> (pc_q == $past(pc_q) + STEP));

    // R5
    r5_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && pend_q) |=> (pc_q == $past(tgt_q)));

    // R5
    r5_pend_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && pend_q && !redirect_set) |=> !pend_q);

    // R11
    r11_hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc_q));
endmodule

// File: rtl/dslot_core.sv
`timescale 1ns/1ps
// Single-cycle core: add-immediate, load-word and delayed branch-if-not-equal.
// Assumes combinational instruction and data ports and that software never
// places a branch in a delay slot. A misaligned load halts the core.
module dslot_core
    import dslot_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 'h1000
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    output logic               dmem_rd_en,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               addr_err,
    output logic               illegal_op
);
    localparam int NREG   = 2 ** RIDX_W;
    localparam int SX_W   = XLEN - IMM_W;
    localparam int ALIGN  = 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    dec_t            dec;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] br_target;
    logic            is_load;
    logic            is_addi;
    logic            is_bne;
    logic            misaligned;
    logic            load_fault;
    logic            retire;
    logic            rf_we;
    logic [XLEN-1:0] rf_wd;
    logic            halted_q;

    dslot_decode u_dec (
        .instr (imem_rdata),
        .dec   (dec)
    );

    dslot_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs_addr (dec.rs),
        .rt_addr (dec.rt),
        .rs_data (rs_val),
        .rt_data (rt_val),
        .we      (rf_we),
        .wa      (dec.rt),
        .wd      (rf_wd)
    );

    // Shared adder for add-immediate results and load addresses.
    always_comb begin
        imm_sx    = {{SX_W{dec.imm[IMM_W-1]}}, dec.imm};
        sum       = rs_val + imm_sx;
        br_target = pc + STEP + (imm_sx << 2);
    end

    // Instruction qualification and fault detection.
    always_comb begin
        is_addi    = !halted_q && dec.kind == KIND_ADDI;
        is_load    = !halted_q && dec.kind == KIND_LOAD;
        is_bne     = !halted_q && dec.kind == KIND_BNE;
        misaligned = sum[ALIGN-1:0] != '0;
        load_fault = is_load && misaligned;
        retire     = !halted_q && !load_fault;
    end

    // Register write selection.
    always_comb begin
        rf_we = retire && (is_addi || is_load);
        rf_wd = is_load ? dmem_rdata : sum;
    end

    dslot_fetch #(
        .XLEN     (XLEN),
        .RESET_PC (RESET_PC)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (retire),
        .redirect_set (is_bne && (rs_val != rt_val)),
        .redirect_pc  (br_target),
        .pc           (pc)
    );

    // Sticky halt flag set by a misaligned load.
    always_ff @(posedge clk) begin
        if (!rst_n)          halted_q <= 1'b0;
        else if (load_fault) halted_q <= 1'b1;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = sum;
    assign dmem_rd_en = is_load && !misaligned;
    assign addr_err   = halted_q;
    assign illegal_op = !halted_q && dec.illegal;

    // R8
    r8_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);

    // R8
    r8_fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fault |=> (addr_err && imem_addr == $past(imem_addr)));

    // R11
    r11_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!dmem_rd_en && !illegal_op));

    // R3
    r3_aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_en |-> (dmem_addr[ALIGN-1:0] == '0));
endmodule

// File: tb/dslot_core_tb_top.sv
`timescale 1ns/1ps
module dslot_core_tb_top;
    localparam logic [31:0] START = 32'h0000_1000;
    localparam logic [5:0] OP_ADDI = 6'b001001;
    localparam logic [5:0] OP_LW   = 6'b100011;
    localparam logic [5:0] OP_BNE  = 6'b000101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = '0;
    logic [31:0] dmem_addr;
    logic        dmem_rd_en;
    logic [31:0] dmem_rdata = '0;
    logic        addr_err;
    logic        illegal_op;

    always #4 clk = ~clk;

    dslot_core #(.XLEN(32), .RESET_PC(START)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rd_en (dmem_rd_en),
        .dmem_rdata (dmem_rdata),
        .addr_err   (addr_err),
        .illegal_op (illegal_op)
    );

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_reg [32];
    logic [31:0] m_pc, m_tgt;
    bit          m_pend, m_err, prev_br;
    logic [31:0] last_pc, last_daddr;
    logic        last_rd, last_ill;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic bit known(input logic [5:0] op);
        return op == OP_ADDI || op == OP_LW || op == OP_BNE;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = START; m_tgt = '0; m_pend = 0; m_err = 0; prev_br = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        imem_rdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk(imem_addr == START, "R1 start address", imem_addr, START);
        chk(addr_err == 1'b0, "R1 error clear", 32'(addr_err), 0);
    endtask

    // Present one instruction at a negedge, check outputs, retire at posedge.
    task automatic step(input logic [31:0] ins, input logic [31:0] ld);
        logic [5:0]  op;
        logic [31:0] ea, nxt;
        int rs, rt;
        bit exp_rd, exp_ill, nxt_pend;
        op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        chk(imem_addr == m_pc, "R7 fetch address", imem_addr, m_pc);
        chk(addr_err == m_err, "R8 error flag", 32'(addr_err), 32'(m_err));
        imem_rdata = ins;
        dmem_rdata = ld;
        #1;
        ea = m_reg[rs] + sx(ins[15:0]);
        exp_rd  = !m_err && op == OP_LW && ea[1:0] == 2'b00;
        exp_ill = !m_err && !known(op);
        chk(dmem_rd_en == exp_rd, "R3 read enable", 32'(dmem_rd_en), 32'(exp_rd));
        if (exp_rd) chk(dmem_addr == ea, "R3 load address", dmem_addr, ea);
        chk(illegal_op == exp_ill, "R9 illegal flag", 32'(illegal_op), 32'(exp_ill));
        last_pc = imem_addr; last_daddr = dmem_addr; last_rd = dmem_rd_en; last_ill = illegal_op;
        @(posedge clk);
        if (!m_err) begin
            nxt = m_pend ? m_tgt : m_pc + 4;
            nxt_pend = 0;
            if (op == OP_ADDI) begin
                if (rt != 0) m_reg[rt] = ea;
            end else if (op == OP_LW) begin
                if (ea[1:0] != 2'b00) begin
                    m_err = 1; nxt = m_pc;
                end else if (rt != 0) m_reg[rt] = ld;
            end else if (op == OP_BNE) begin
                if (m_reg[rs] != m_reg[rt]) begin
                    nxt_pend = 1; m_tgt = m_pc + 4 + (sx(ins[15:0]) << 2);
                end
            end
            m_pc = nxt; m_pend = nxt_pend;
        end
        prev_br = (op == OP_BNE);
        @(negedge clk);
    endtask

    // Expose a register value through the load address (load into register 0).
    task automatic peek(input int r, input logic [31:0] exp, input string tag);
        step(enc(OP_LW, r, 0, 16'h0000), 32'hFEED_0000);
        chk(last_daddr == exp, tag, last_daddr, exp);
    endtask

    initial begin
        #(8ns * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R2: wrap and sign extension
        step(enc(OP_LW, 0, 1, 16'h0000), 32'hFFFF_FFFC);
        step(enc(OP_ADDI, 1, 2, 16'h0004), 32'h0);
        peek(2, 32'h0000_0000, "R2 modulo wrap");
        step(enc(OP_ADDI, 0, 3, 16'hFFF8), 32'h0);
        peek(3, 32'hFFFF_FFF8, "R2 sign extend");

        // R4: register zero
        step(enc(OP_ADDI, 0, 0, 16'h0064), 32'h0);
        step(enc(OP_LW, 0, 0, 16'h0000), 32'h1234_5678);
        peek(0, 32'h0000_0000, "R4 zero register");

        // R3: load writeback and negative offset
        step(enc(OP_LW, 0, 5, 16'h0008), 32'h0000_1230);
        peek(5, 32'h0000_1230, "R3 load writeback");
        step(enc(OP_LW, 5, 6, 16'hFFFC), 32'h0);
        chk(last_daddr == 32'h0000_122C, "R3 effective address", last_daddr, 32'h0000_122C);

        // R5: taken forward branch with delay slot
        step(enc(OP_ADDI, 0, 7, 16'h0004), 32'h0);
        p = imem_addr;
        step(enc(OP_BNE, 7, 0, 16'h0003), 32'h0);
        chk(imem_addr == p + 4, "R5 delay slot fetched", imem_addr, p + 4);
        step(enc(OP_ADDI, 0, 8, 16'h000C), 32'h0);
        chk(imem_addr == p + 16, "R5 forward target", imem_addr, p + 16);
        peek(8, 32'h0000_000C, "R5 delay slot executed");

        // R5: taken backward branch
        p = imem_addr;
        step(enc(OP_BNE, 0, 7, 16'hFFFE), 32'h0);
        step(enc(OP_ADDI, 0, 0, 16'h0000), 32'h0);
        chk(imem_addr == p - 4, "R5 backward target", imem_addr, p - 4);

        // R6: untaken branch
        p = imem_addr;
        step(enc(OP_BNE, 7, 7, 16'h0005), 32'h0);
        step(enc(OP_ADDI, 0, 0, 16'h0000), 32'h0);
        chk(imem_addr == p + 8, "R6 not taken", imem_addr, p + 8);

        // R9: unknown opcode
        step(enc(6'b111111, 0, 9, 16'h0040), 32'h0);
        chk(last_ill == 1'b1, "R9 flag raised", 32'(last_ill), 1);
        peek(9, 32'h0000_0000, "R9 no register write");

        // R8 and R11: misaligned load then halted
        p = imem_addr;
        step(enc(OP_LW, 0, 10, 16'h0002), 32'h0);
        chk(last_rd == 1'b0, "R8 no read on misaligned", 32'(last_rd), 0);
        chk(addr_err == 1'b1, "R8 error raised", 32'(addr_err), 1);
        chk(imem_addr == p, "R8 fetch held", imem_addr, p);
        step(enc(6'b111111, 0, 0, 16'h0000), 32'h0);
        chk(last_ill == 1'b0, "R11 illegal masked", 32'(last_ill), 0);
        step(enc(OP_LW, 0, 4, 16'h0000), 32'h0);
        chk(last_rd == 1'b0, "R11 load masked", 32'(last_rd), 0);
        chk(imem_addr == p, "R11 fetch frozen", imem_addr, p);

        // R10: delay slot faults while redirect pending
        do_reset();
        step(enc(OP_ADDI, 0, 1, 16'h0004), 32'h0);
        p = imem_addr;
        step(enc(OP_BNE, 1, 0, 16'h0008), 32'h0);
        step(enc(OP_LW, 0, 2, 16'h0001), 32'h0);
        chk(addr_err == 1'b1, "R10 error on slot", 32'(addr_err), 1);
        chk(imem_addr == p + 4, "R10 held on slot", imem_addr, p + 4);
        step(enc(OP_ADDI, 0, 3, 16'h0001), 32'h0);
        chk(imem_addr == p + 4, "R10 target never fetched", imem_addr, p + 4);

        // Random streams checked by the model (R2 R3 R5 R6 R7 R9)
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            int kind, rs, rt;
            logic [31:0] r, ins;
            logic [1:0] fix;
            r = $urandom;
            rs = int'($urandom % 32); rt = int'($urandom % 32);
            kind = int'($urandom % 10);
            if (prev_br && kind >= 6 && kind <= 7) kind = 0;
            if (kind < 3) ins = enc(OP_ADDI, rs, rt, r[15:0]);
            else if (kind < 6) begin
                fix = 2'(32'd0 - m_reg[rs]);
                ins = enc(OP_LW, rs, rt, {r[15:2], fix});
            end else if (kind < 8) ins = enc(OP_BNE, rs, rt, r[15:0]);
            else if (kind < 9) ins = enc(6'(r[31:26] == OP_ADDI || r[31:26] == OP_LW || r[31:26] == OP_BNE ? 6'b110111 : r[31:26]), rs, rt, r[15:0]);
            else ins = enc(OP_ADDI, 0, rt, r[15:0]);
            step(ins, $urandom);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule